// File: doc/BRIEF.md
# Five-Step Skip Counter

This block is a small state counter that walks a fixed loop of five codes: 0, 3, 5, 7, 6, and then back to 0. It does not count in binary order. Each rising clock edge with the step enable high moves it one place along the loop. With the enable low, the value stays where it is. A registered flag marks the step that closes the loop, so a neighbouring block can count whole laps without decoding the state itself.

Codes 1, 2 and 4 are not on the loop. The counter can still reach them through a load port or an upset. From any of these codes, the next enabled step returns the counter to 0, so it never locks up. The load port also lets a test place the counter on any code in one cycle.

The loop contents, the state width and the recovery code are parameters, and elaboration checks them. The defaults give the five-code loop above in three state bits.

Top module: `cyc5_counter`

## Requirements
- R1: When `rst_i` is high at a rising edge, the next cycle shows `state_o` = 0 and `wrap_o` = 0, whatever `en_i` and `ld_i` are.
- R2: With `rst_i` and `ld_i` low and `en_i` high, each rising edge moves `state_o` one place along the loop 0→3→5→7→6→0.
- R3: With `rst_i`, `ld_i` and `en_i` all low at an edge, `state_o` keeps its value in the next cycle and `wrap_o` is 0. This holds on every code, including codes 1, 2 and 4.
- R4: With `rst_i` low and `ld_i` high at an edge, the next cycle shows `state_o` = `ld_val_i` and `wrap_o` = 0. This happens whatever `en_i` is, so a load takes priority over a step.
- R5: With `state_o` at 1, 2 or 4 and an enabled step (`en_i` high, `ld_i` and `rst_i` low), the next cycle shows `state_o` = 0 and `wrap_o` = 0.
- R6: `wrap_o` is 1 for exactly the one cycle that follows an enabled step from 6 to 0. It is 0 in every other cycle.
- R7: When `rst_i` and `ld_i` are both high at an edge, the reset wins, and the next cycle shows `state_o` = 0 and `wrap_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high, highest priority |
| en_i | input | 1 | Step enable |
| ld_i | input | 1 | Load strobe; places `ld_val_i` in the state, above stepping |
| ld_val_i | input | 3 | Code to load |
| state_o | output | 3 | Current counter code |
| wrap_o | output | 1 | High for one cycle after the 6→0 step |

## Verification
Every result of this block appears exactly one rising edge after the inputs that cause it. This covers the stepped, held, loaded or reset value of `state_o`, and the `wrap_o` pulse. The bench drives the inputs on the falling edge and advances its behavioural model by one step for that edge. It then compares both outputs on the next falling edge, half a period after the rising edge that should have produced them. It places the counter on each unused code through the load port and takes one enabled step from there. It also checks that `wrap_o` drops again one edge after the 6→0 step.

// File: rtl/cyc5_pkg.sv
package cyc5_pkg;

   // Default geometry: three state bits, five codes in the loop.
   localparam int unsigned CYC_STATE_W = 3;
   localparam int unsigned CYC_SEQ_LEN = 5;

   // Loop codes packed with entry 0 in the low bits: 0, 3, 5, 7, 6.
   localparam logic [CYC_SEQ_LEN*CYC_STATE_W-1:0] CYC_SEQ_DFLT =
      {3'd6, 3'd7, 3'd5, 3'd3, 3'd0};

   // Per-edge action chosen from the control inputs.
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_STEP  = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_CLEAR = 2'd3
   } cyc_act_e;

endpackage

// File: rtl/cyc5_ctrl.sv
module cyc5_ctrl
   import cyc5_pkg::*;
(
   input  logic     rst_i,
   input  logic     en_i,
   input  logic     ld_i,
   output cyc_act_e act_o
);

   // Priority order: clear, then load, then step, then hold.
   always_comb begin
      if (rst_i)      act_o = ACT_CLEAR;
      else if (ld_i)  act_o = ACT_LOAD;
      else if (en_i)  act_o = ACT_STEP;
      else            act_o = ACT_HOLD;
   end

endmodule

// File: rtl/cyc5_next.sv
module cyc5_next #(
   parameter int unsigned W       = 3,
   parameter int unsigned LEN     = 5,
   parameter logic [LEN*W-1:0] SEQ = '0,
   parameter logic [W-1:0] RECOVER = '0
) (
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o,
   output logic         wrap_o,
   output logic         known_o
);

   logic [LEN-1:0] hit;

   // One comparator per loop entry.
   generate
      for (genvar i = 0; i < LEN; i++) begin : g_hit
         assign hit[i] = (cur_i == SEQ[i*W +: W]);
      end
   endgenerate

   // Elaboration check: every loop code appears only once.
   generate
      for (genvar a = 0; a < LEN; a++) begin : g_dup_a
         for (genvar b = a + 1; b < LEN; b++) begin : g_dup_b
            if (SEQ[a*W +: W] == SEQ[b*W +: W]) begin : g_dup_err
               $error("cyc5_next: loop code listed twice");
            end
         end
      end
   endgenerate

   // Successor lookup. A code off the loop goes to the recovery code.
   always_comb begin
      nxt_o   = RECOVER;
      wrap_o  = 1'b0;
      known_o = |hit;
      for (int k = 0; k < LEN; k++) begin
         if (hit[k]) begin
            nxt_o  = SEQ[((k + 1) % LEN) * W +: W];
            wrap_o = (k == LEN - 1);
         end
      end
   end

   // Distinct codes mean at most one comparator fires.
   always_comb begin
      onehot_hit_chk: assert ($onehot0(hit));
   end

endmodule

// File: rtl/cyc5_state_reg.sv
module cyc5_state_reg
   import cyc5_pkg::*;
#(
   parameter int unsigned W = 3,
   parameter logic [W-1:0] RST_CODE = '0
) (
   input  logic         clk_i,
   input  cyc_act_e     act_i,
   input  logic [W-1:0] load_val_i,
   input  logic [W-1:0] step_val_i,
   input  logic         step_wrap_i,
   output logic [W-1:0] state_o,
   output logic         wrap_o
);

   always_ff @(posedge clk_i) begin
      unique case (act_i)
         ACT_CLEAR: begin
            state_o <= RST_CODE;
            wrap_o  <= 1'b0;
         end
         ACT_LOAD: begin
            state_o <= load_val_i;
            wrap_o  <= 1'b0;
         end
         ACT_STEP: begin
            state_o <= step_val_i;
            wrap_o  <= step_wrap_i;
         end
         default: begin
            wrap_o  <= 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/cyc5_counter.sv
module cyc5_counter
   import cyc5_pkg::*;
#(
   parameter int unsigned STATE_W = CYC_STATE_W,
   parameter int unsigned SEQ_LEN = CYC_SEQ_LEN,
   parameter logic [SEQ_LEN*STATE_W-1:0] SEQ_CODES = CYC_SEQ_DFLT,
   parameter logic [STATE_W-1:0] RECOVER_CODE = '0
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   input  logic               ld_i,
   input  logic [STATE_W-1:0] ld_val_i,
   output logic [STATE_W-1:0] state_o,
   output logic               wrap_o
);

   localparam logic [STATE_W-1:0] FIRST_CODE  = SEQ_CODES[0 +: STATE_W];
   localparam logic [STATE_W-1:0] SECOND_CODE = SEQ_CODES[STATE_W +: STATE_W];
   localparam logic [STATE_W-1:0] LAST_CODE   = SEQ_CODES[(SEQ_LEN-1)*STATE_W +: STATE_W];

   function automatic bit code_listed(input logic [STATE_W-1:0] c);
      bit found = 1'b0;
      for (int i = 0; i < SEQ_LEN; i++)
         if (SEQ_CODES[i*STATE_W +: STATE_W] == c) found = 1'b1;
      return found;
   endfunction

   // Elaboration checks on the loop parameters.
   generate
      if (SEQ_LEN < 2) begin : g_len_err
         $error("cyc5_counter: loop needs at least two codes");
      end
      if (SEQ_LEN > (1 << STATE_W)) begin : g_fit_err
         $error("cyc5_counter: loop longer than the code space");
      end
      if (!code_listed(RECOVER_CODE)) begin : g_rec_err
         $error("cyc5_counter: recovery code must lie on the loop");
      end
   endgenerate

   cyc_act_e           act;
   logic [STATE_W-1:0] step_val;
   logic               step_wrap;
   logic               seq_known;

   cyc5_ctrl u_ctrl (
      .rst_i (rst_i),
      .en_i  (en_i),
      .ld_i  (ld_i),
      .act_o (act)
   );

   cyc5_next #(
      .W       (STATE_W),
      .LEN     (SEQ_LEN),
      .SEQ     (SEQ_CODES),
      .RECOVER (RECOVER_CODE)
   ) u_next (
      .cur_i   (state_o),
      .nxt_o   (step_val),
      .wrap_o  (step_wrap),
      .known_o (seq_known)
   );

   cyc5_state_reg #(
      .W        (STATE_W),
      .RST_CODE (FIRST_CODE)
   ) u_reg (
      .clk_i       (clk_i),
      .act_i       (act),
      .load_val_i  (ld_val_i),
      .step_val_i  (step_val),
      .step_wrap_i (step_wrap),
      .state_o     (state_o),
      .wrap_o      (wrap_o)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk_i)
      rst_i |=> (state_o == FIRST_CODE && !wrap_o));

   // R2
   first_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !ld_i && state_o == FIRST_CODE) |=> (state_o == SECOND_CODE));

   // R3
   hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!en_i && !ld_i) |=> ($stable(state_o) && !wrap_o));

   // R4
   load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ld_i |=> (state_o == $past(ld_val_i) && !wrap_o));

   // R5
   recover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !ld_i && !seq_known) |=> (state_o == RECOVER_CODE && !wrap_o));

   // R6
   wrap_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !ld_i && state_o == LAST_CODE) |=> (wrap_o && state_o == FIRST_CODE));

   // R6
   wrap_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      wrap_o |-> ($past(state_o) == LAST_CODE && $past(en_i) && !$past(ld_i)));

endmodule

// File: tb/cyc5_counter_tb.sv
module cyc5_counter_tb;

   logic       clk = 1'b0;
   logic       rst, en, ld;
   logic [2:0] ldv;
   logic [2:0] st;
   logic       wr;

   int errors = 0;
   int checks = 0;
   int exp_st = 0;
   bit exp_wr = 1'b0;
   int order[$] = '{0, 3, 5, 7, 6};

   always #10 clk = ~clk;

   cyc5_counter u_dut (
      .clk_i    (clk),
      .rst_i    (rst),
      .en_i     (en),
      .ld_i     (ld),
      .ld_val_i (ldv),
      .state_o  (st),
      .wrap_o   (wr)
   );

   task automatic model(input bit r, input bit e, input bit l, input int v);
      int idx;
      idx = -1;
      if (r) begin
         exp_st = 0; exp_wr = 1'b0;
      end else if (l) begin
         exp_st = v & 7; exp_wr = 1'b0;
      end else if (e) begin
         foreach (order[i]) if (order[i] == exp_st) idx = i;
         if (idx < 0) begin
            exp_st = 0; exp_wr = 1'b0;
         end else begin
            exp_wr = (idx == order.size() - 1);
            exp_st = order[(idx + 1) % order.size()];
         end
      end else begin
         exp_wr = 1'b0;
      end
   endtask

   task automatic cyc(input bit r, input bit e, input bit l, input int v, input string tag);
      rst = r; en = e; ld = l; ldv = v[2:0];
      model(r, e, l, v);
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (st !== exp_st[2:0] || wr !== exp_wr) begin
         errors++;
         $display("FAIL %s: state=%0d wrap=%0b expected state=%0d wrap=%0b",
                  tag, st, wr, exp_st, exp_wr);
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1'b1; en = 1'b0; ld = 1'b0; ldv = '0;
      // R1: reset with step and load requested
      cyc(1, 1, 0, 0, "R1");
      cyc(1, 1, 1, 5, "R1");
      // R2 / R6: two full laps
      for (int n = 0; n < 10; n++) cyc(0, 1, 0, 0, (n % 5 == 4) ? "R6" : "R2");
      // R6: wrap drops after one cycle when held
      cyc(0, 1, 0, 0, "R2");
      cyc(0, 1, 0, 0, "R2");
      cyc(0, 1, 0, 0, "R2");
      cyc(0, 1, 0, 0, "R2");
      cyc(0, 1, 0, 0, "R6");
      cyc(0, 0, 0, 0, "R6");
      // R3: hold on loop codes
      cyc(0, 1, 0, 0, "R2");
      cyc(0, 0, 0, 0, "R3");
      cyc(0, 0, 0, 0, "R3");
      // R4 and R5: every code loaded, held, then stepped
      for (int c = 0; c < 8; c++) begin
         cyc(0, c[0], 1, c, "R4");
         cyc(0, 0, 0, 0, "R3");
         cyc(0, 1, 0, 0, (c == 1 || c == 2 || c == 4) ? "R5" : "R2");
      end
      // R5: unused code reached through a load while enable is high
      cyc(0, 1, 1, 4, "R4");
      cyc(0, 1, 0, 0, "R5");
      cyc(0, 1, 0, 0, "R2");
      // R6: load last code then step into the wrap
      cyc(0, 0, 1, 6, "R4");
      cyc(0, 1, 0, 0, "R6");
      cyc(0, 1, 0, 0, "R6");
      // R7: reset beats load
      cyc(0, 0, 1, 7, "R4");
      cyc(1, 0, 1, 2, "R7");
      cyc(0, 0, 0, 0, "R3");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule